// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps wall-clock time and date as eight packed-BCD fields: century, year, month, day of month, weekday, hours (24-hour), minutes and seconds. An internal set of counters advances by one second on every pulse of a once-per-second tick input. The host sees a second, external copy of the fields. While the block is running, that copy follows the counters. When the host sets a freeze bit, the copy holds still. The host can then read a consistent snapshot, and can also write new values into it. When the freeze bit is cleared, any fields written during the freeze are loaded into the counters.

The host reaches the block through an asynchronous-read, synchronous-write byte port that looks like ordinary static memory. The block occupies the top 16 byte addresses of the address space. A read below that window returns zero and raises a miss flag, so that a neighbouring RAM can drive the bus instead. The calendar handles month lengths, leap years and the year-to-century carry by itself.

Top module: `rtc_dbuf_clock`

## Requirements
- R1: After reset the fields read century 0x20, year 0x00, month 0x01, date 0x01, weekday 0x01, hours 0x00, minutes 0x00, seconds 0x00, and the control byte reads 0x00.
- R2: The window is the top 16 addresses. Offset 0x0 is control, and bit 0 of it is the freeze bit. Offsets 0x1 to 0x8 hold seconds, minutes, hours, weekday, date, month, year and century in that order. Offsets 0x9 to 0xF read 0x00.
- R3: On a tick, seconds roll from 0x59 to 0x00 and carry into minutes. Minutes roll from 0x59 to 0x00 and carry into hours. Hours roll from 0x23 to 0x00 and start a new day.
- R4: On each new day, the weekday goes from 0x07 to 0x01 and otherwise increments by one.
- R5: The date rolls to 0x01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the two-digit year is a multiple of 4 (including 00), and 28 otherwise. All other months have 31 days.
- R6: The month rolls from 0x12 to 0x01 and increments the year. The year rolls from 0x99 to 0x00 and increments the BCD century.
- R7: The internal counters keep advancing while the external copy is frozen. Clearing the freeze bit without any field writes makes the external copy show the current counter values.
- R8: While frozen, the field values read by the host do not change on ticks.
- R9: Fields written while frozen are loaded into the counters when the freeze bit is cleared. On that cycle the load takes precedence over a coincident tick, and counting then resumes from the loaded values.
- R10: Field writes made while not frozen are ignored.
- R11: With cs high and the address below the window, rdata is 0x00 and miss is 1, and writes there change nothing in the block. With cs low, rdata is 0x00 and miss is 0. Inside the window, miss is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Chip select for the host port |
| we | input | 1 | Write strobe, sampled on the clock edge when cs is high |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| miss | output | 1 | Selected address lies below the clock window |

## Verification
The hardest case to reach from the ports is the release cycle. In that cycle the counters are loaded from dirty external fields while a tick arrives at the same time, and the carry chain may be sitting on a month or century boundary. The bench reaches it by freezing, writing a full date that sits one or two ticks before a boundary, and clearing the freeze bit. For the precedence case, the tick pulse is placed on the same cycle as the control write. A behavioural model compares the byte read back on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef logic [7:0] bcd8_t;

   localparam int NUM_FIELDS = 8;
   localparam int FI_SEC   = 0;
   localparam int FI_MIN   = 1;
   localparam int FI_HOUR  = 2;
   localparam int FI_WDAY  = 3;
   localparam int FI_DATE  = 4;
   localparam int FI_MONTH = 5;
   localparam int FI_YEAR  = 6;
   localparam int FI_CENT  = 7;

   function automatic bcd8_t bcd_inc(bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic bcd8_t fld_lo(int f);
      case (f)
         FI_WDAY, FI_DATE, FI_MONTH: return 8'h01;
         default:                    return 8'h00;
      endcase
   endfunction

   function automatic bcd8_t fld_hi(int f);
      case (f)
         FI_SEC, FI_MIN:   return 8'h59;
         FI_HOUR:          return 8'h23;
         FI_WDAY:          return 8'h07;
         FI_DATE:          return 8'h31;
         FI_MONTH:         return 8'h12;
         default:          return 8'h99;
      endcase
   endfunction

   // index of the field whose wrap advances field f
   function automatic int fld_src(int f);
      case (f)
         FI_MIN:           return FI_SEC;
         FI_HOUR:          return FI_MIN;
         FI_WDAY, FI_DATE: return FI_HOUR;
         FI_MONTH:         return FI_DATE;
         FI_YEAR:          return FI_MONTH;
         FI_CENT:          return FI_YEAR;
         default:          return FI_SEC;
      endcase
   endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
   import rtc_pkg::*;
(
   input  bcd8_t month,
   input  bcd8_t year,
   output bcd8_t days
);
   // year = 10*t + u is a multiple of 4 exactly when (2*t + u) is
   logic [1:0] mod4;
   logic       leap;
   logic       unused_year_bits;

   assign mod4 = year[1:0] + {year[4], 1'b0};
   assign leap = (mod4 == 2'd0);
   assign unused_year_bits = ^{year[7:5], year[3:2]};

   always_comb begin
      case (month)
         8'h02:                      days = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: days = 8'h30;
         default:                    days = 8'h31;
      endcase
   end

endmodule

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr
   import rtc_pkg::*;
#(
   parameter bcd8_t LO      = 8'h00,
   parameter bcd8_t HI      = 8'h59,
   parameter bcd8_t RST_VAL = 8'h00,
   parameter bit    VAR_HI  = 1'b0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  bcd8_t load_val,
   input  logic  inc,
   input  bcd8_t hi_var,
   output bcd8_t q,
   output bcd8_t nxt,
   output logic  wrap
);
   bcd8_t top_val;

   if (VAR_HI) begin : g_var_top
      assign top_val = hi_var;
   end else begin : g_fix_top
      logic unused_hi;
      assign unused_hi = ^hi_var;
      assign top_val   = HI;
   end

   assign wrap = inc & ~load & (q >= top_val);

   always_comb begin
      if (load)     nxt = load_val;
      else if (inc) nxt = (q >= top_val) ? LO : bcd_inc(q);
      else          nxt = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

   // R3: a field at its top value returns to its bottom value on the next edge
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (q == LO));

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
   import rtc_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int NF       = 8,
   parameter int HALT_BIT = 0
)(
   input  logic                 cs,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NF-1:0][7:0]   ext,
   input  logic                 halt,
   output bcd8_t                rdata,
   output logic                 miss,
   output logic                 ctrl_wr,
   output logic [NF-1:0]        fld_wr
);
   localparam int OFF_W = 4;

   logic             in_win;
   logic [OFF_W-1:0] off;
   logic             wr;

   assign in_win  = &addr[ADDR_W-1:OFF_W];
   assign off     = addr[OFF_W-1:0];
   assign wr      = cs & we & in_win;
   assign ctrl_wr = wr & (off == '0);
   assign miss    = cs & ~in_win;

   for (genvar f = 0; f < NF; f++) begin : g_dec
      assign fld_wr[f] = wr & (off == OFF_W'(f + 1));
   end

   always_comb begin
      rdata = '0;
      if (cs && in_win) begin
         if (off == '0) rdata[HALT_BIT] = halt;
         for (int f = 0; f < NF; f++)
            if (off == OFF_W'(f + 1)) rdata = ext[f];
      end
   end

endmodule

// File: rtl/rtc_dbuf_clock.sv
module rtc_dbuf_clock
   import rtc_pkg::*;
#(
   parameter int    ADDR_W      = 13,
   parameter int    HALT_BIT    = 0,
   parameter bcd8_t RST_CENTURY = 8'h20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              miss
);
   localparam int NF = NUM_FIELDS;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must leave room above a 16-byte window");
   end
   if (HALT_BIT < 0 || HALT_BIT > 7) begin : g_bad_bit
      $error("HALT_BIT must lie inside the control byte");
   end
   if (NF + 1 > 16) begin : g_bad_nf
      $error("fields plus control must fit in 16 offsets");
   end

   logic [NF-1:0][7:0] int_q, int_nxt, ext_q;
   logic [NF-1:0]      inc, wrap, fld_wr;
   logic               ctrl_wr, halt_q, halt_nx, release_c, dirty_q, load_all;
   bcd8_t              mlen;
   logic               unused_wraps;

   assign halt_nx   = ctrl_wr ? wdata[HALT_BIT] : halt_q;
   assign release_c = halt_q & ~halt_nx;
   assign load_all  = release_c & dirty_q;
   assign unused_wraps = wrap[FI_WDAY] ^ wrap[FI_CENT];

   rtc_host_port #(.ADDR_W(ADDR_W), .NF(NF), .HALT_BIT(HALT_BIT)) u_port (
      .cs(cs), .we(we), .addr(addr), .ext(ext_q), .halt(halt_q),
      .rdata(rdata), .miss(miss), .ctrl_wr(ctrl_wr), .fld_wr(fld_wr)
   );

   rtc_month_len u_mlen (
      .month(int_q[FI_MONTH]), .year(int_q[FI_YEAR]), .days(mlen)
   );

   for (genvar f = 0; f < NF; f++) begin : g_fld
      localparam bcd8_t RV = (f == FI_CENT) ? RST_CENTURY : fld_lo(f);

      if (f == FI_SEC) begin : g_head
         assign inc[f] = tick_1hz & ~load_all;
      end else begin : g_chain
         assign inc[f] = wrap[fld_src(f)];
      end

      rtc_field_ctr #(
         .LO(fld_lo(f)), .HI(fld_hi(f)), .RST_VAL(RV), .VAR_HI(f == FI_DATE)
      ) u_ctr (
         .clk(clk), .rst_n(rst_n), .load(load_all), .load_val(ext_q[f]),
         .inc(inc[f]), .hi_var(mlen), .q(int_q[f]), .nxt(int_nxt[f]),
         .wrap(wrap[f])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   ext_q[f] <= RV;
         else if (!halt_nx)            ext_q[f] <= int_nxt[f];
         else if (halt_q && fld_wr[f]) ext_q[f] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         halt_q <= halt_nx;
         if (release_c)                dirty_q <= 1'b0;
         else if (halt_q && |fld_wr)   dirty_q <= 1'b1;
      end
   end

   // R7: while running, the host copy equals the counters
   a_r7_track: assert property (@(posedge clk) disable iff (!rst_n)
      !halt_q |-> (ext_q == int_q));

   // R7: counters keep moving while the host copy is frozen
   a_r7_runs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && tick_1hz && !ctrl_wr) |=> (int_q != $past(int_q)));

   // R8: no write and still frozen means the host copy holds
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !(cs && we)) |=> $stable(ext_q));

   // R9: a dirty release copies the host fields into the counters
   a_r9_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      load_all |=> (int_q == $past(ext_q)));

   // R11: an address below the window drives a quiet bus
   a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (rdata == 8'h00));

endmodule

// File: tb/test_rtc_dbuf_clock.sv
module test_rtc_dbuf_clock;
   localparam int AW   = 13;
   localparam int BASE = (1 << AW) - 16;

   logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cs = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          miss;

   always #5 clk = ~clk;

   rtc_dbuf_clock i_rtc_dbuf_clock (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .cs(cs), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata), .miss(miss)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";

   // model state, index: 0 sec,1 min,2 hour,3 wday,4 date,5 month,6 year,7 century
   logic [7:0] m_int [8];
   logic [7:0] m_ext [8];
   logic [7:0] nx    [8];
   bit         m_halt, m_dirty;

   function automatic int b2d(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic logic [7:0] d2b(int d);
      return {4'(d / 10), 4'(d % 10)};
   endfunction
   function automatic int dim(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_int[i] = 8'h00;
      m_int[3] = 8'h01; m_int[4] = 8'h01; m_int[5] = 8'h01; m_int[7] = 8'h20;
      m_ext = m_int;
      m_halt = 0; m_dirty = 0;
   endtask

   task automatic advance();
      int s, mi, h, wd, dt, mo, yr, ce;
      s = b2d(nx[0]); mi = b2d(nx[1]); h = b2d(nx[2]); wd = b2d(nx[3]);
      dt = b2d(nx[4]); mo = b2d(nx[5]); yr = b2d(nx[6]); ce = b2d(nx[7]);
      s++;
      if (s > 59) begin
         s = 0; mi++;
         if (mi > 59) begin
            mi = 0; h++;
            if (h > 23) begin
               h = 0;
               wd = (wd == 7) ? 1 : wd + 1;
               dt++;
               if (dt > dim(mo, yr)) begin
                  dt = 1; mo++;
                  if (mo > 12) begin
                     mo = 1; yr++;
                     if (yr > 99) begin
                        yr = 0;
                        ce = (ce == 99) ? 0 : ce + 1;
                     end
                  end
               end
            end
         end
      end
      nx[0] = d2b(s); nx[1] = d2b(mi); nx[2] = d2b(h); nx[3] = d2b(wd);
      nx[4] = d2b(dt); nx[5] = d2b(mo); nx[6] = d2b(yr); nx[7] = d2b(ce);
   endtask

   initial model_reset();

   always @(posedge clk) begin : model_step
      bit in_win, wr, hn, rel, fw;
      int off;
      cyc++;
      if (!rst_n) model_reset();
      else begin
         in_win = (addr[AW-1:4] == '1);
         off    = int'(addr[3:0]);
         wr     = cs && we && in_win;
         fw     = wr && off >= 1 && off <= 8;
         hn     = (wr && off == 0) ? wdata[0] : m_halt;
         rel    = m_halt && !hn;
         nx     = m_int;
         if (tick) advance();
         if (rel && m_dirty) nx = m_ext;
         if (!hn) m_ext = nx;
         else if (m_halt && fw) m_ext[off-1] = wdata;
         if (rel) m_dirty = 0;
         else if (m_halt && fw) m_dirty = 1;
         m_halt = hn;
         m_int  = nx;
      end
   end

   always @(negedge clk) begin : compare
      bit in_win;
      int off;
      logic [7:0] exp_d;
      bit exp_m;
      if (rst_n) begin
         in_win = (addr[AW-1:4] == '1);
         off    = int'(addr[3:0]);
         exp_d  = 8'h00;
         if (cs && in_win) begin
            if (off == 0) exp_d = {7'd0, m_halt};
            else if (off <= 8) exp_d = m_ext[off-1];
         end
         exp_m = cs && !in_win;
         chk(rdata === exp_d, {cur_req, " model data"}, rdata, exp_d);
         chk(miss === exp_m, {cur_req, " model miss"}, miss, exp_m);
      end
   end

   always @(posedge clk) begin
      if (cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic drive(input bit c, input bit w, input int a, input int d, input bit t);
      @(negedge clk); #2;
      cs = c; we = w; addr = AW'(a); wdata = 8'(d); tick = t;
   endtask

   task automatic expect_rd(input int off, input int val, input string tag);
      drive(1, 0, BASE + off, 0, 0);
      @(negedge clk); #1;
      chk(rdata === 8'(val), tag, rdata, val);
   endtask

   task automatic set_time(input int ce, yr, mo, dt, wd, h, mi, s);
      drive(1, 1, BASE, 1, 0);
      drive(1, 1, BASE + 1, s, 0);  drive(1, 1, BASE + 2, mi, 0);
      drive(1, 1, BASE + 3, h, 0);  drive(1, 1, BASE + 4, wd, 0);
      drive(1, 1, BASE + 5, dt, 0); drive(1, 1, BASE + 6, mo, 0);
      drive(1, 1, BASE + 7, yr, 0); drive(1, 1, BASE + 8, ce, 0);
      drive(1, 1, BASE, 0, 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         drive(1, 0, BASE + 1 + (i % 8), 0, 1);
         drive(1, 0, BASE + 1 + ((i + 3) % 8), 0, 0);
      end
   endtask

   initial begin
      repeat (3) drive(0, 0, 0, 0, 0);
      @(negedge clk); #2; rst_n = 1'b1;

      cur_req = "R1";
      expect_rd(0, 8'h00, "R1 control");  expect_rd(1, 8'h00, "R1 sec");
      expect_rd(2, 8'h00, "R1 min");      expect_rd(3, 8'h00, "R1 hour");
      expect_rd(4, 8'h01, "R1 wday");     expect_rd(5, 8'h01, "R1 date");
      expect_rd(6, 8'h01, "R1 month");    expect_rd(7, 8'h00, "R1 year");
      expect_rd(8, 8'h20, "R1 century");

      cur_req = "R2";
      for (int o = 9; o < 16; o++) expect_rd(o, 8'h00, "R2 reserved");
      drive(1, 1, BASE, 1, 0);
      expect_rd(0, 8'h01, "R2 freeze bit");
      drive(1, 1, BASE, 0, 0);

      cur_req = "R10";
      drive(1, 1, BASE + 1, 8'h33, 0);
      expect_rd(1, 8'h00, "R10 write ignored when running");

      cur_req = "R3";
      set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
      ticks(2);
      expect_rd(1, 8'h00, "R3 sec wrap");  expect_rd(2, 8'h00, "R3 min wrap");
      expect_rd(3, 8'h00, "R3 hour wrap");
      cur_req = "R4";
      expect_rd(4, 8'h01, "R4 wday 7 to 1");
      cur_req = "R6";
      expect_rd(5, 8'h01, "R6 date");     expect_rd(6, 8'h01, "R6 month wrap");
      expect_rd(7, 8'h00, "R6 year wrap"); expect_rd(8, 8'h21, "R6 century");
      ticks(3);

      cur_req = "R5";
      set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      ticks(1);
      expect_rd(5, 8'h29, "R5 leap year 00");
      set_time(8'h20, 8'h01, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      ticks(1);
      expect_rd(5, 8'h01, "R5 plain feb");  expect_rd(6, 8'h03, "R5 to march");
      set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
      ticks(1);
      expect_rd(6, 8'h03, "R5 leap feb end");
      set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
      ticks(1);
      expect_rd(5, 8'h01, "R5 april end");   expect_rd(6, 8'h05, "R5 to may");
      set_time(8'h20, 8'h23, 8'h01, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
      ticks(1);
      expect_rd(6, 8'h02, "R5 january end"); expect_rd(4, 8'h07, "R4 wday 6 to 7");

      cur_req = "R8";
      drive(1, 1, BASE, 1, 0);
      ticks(5);
      expect_rd(1, 8'h00, "R8 frozen sec");
      cur_req = "R7";
      drive(1, 1, BASE, 0, 0);
      expect_rd(1, 8'h05, "R7 resync after freeze");

      cur_req = "R9";
      drive(1, 1, BASE, 1, 0);
      drive(1, 1, BASE + 1, 8'h40, 0);
      drive(1, 1, BASE, 0, 1);
      expect_rd(1, 8'h40, "R9 load beats tick");
      ticks(1);
      expect_rd(1, 8'h41, "R9 resumes");

      cur_req = "R11";
      drive(1, 0, 0, 0, 0);
      @(negedge clk); #1;
      chk(miss === 1'b1 && rdata === 8'h00, "R11 low address", {miss, rdata}, 9'h100);
      drive(1, 0, BASE - 1, 0, 0);
      @(negedge clk); #1;
      chk(miss === 1'b1 && rdata === 8'h00, "R11 just below", {miss, rdata}, 9'h100);
      drive(0, 0, BASE + 1, 0, 0);
      @(negedge clk); #1;
      chk(miss === 1'b0 && rdata === 8'h00, "R11 deselected", {miss, rdata}, 9'h000);
      drive(1, 1, BASE, 1, 0);
      drive(1, 1, BASE - 15, 8'h12, 0);
      drive(1, 1, BASE, 0, 0);
      expect_rd(1, 8'h41, "R11 outside write ignored");

      drive(0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule